// File: doc/BRIEF.md
# Mailbox Requester Sequencer

This block is a host-side engine that carries out one request/response exchange with a data-object mailbox. It reaches the mailbox through a simple port that does one dword register access at a time. A task is started with a one-cycle pulse. The task gives a vendor identifier, an object type, the request payload size in bytes and the response buffer capacity in bytes. The engine pulls request payload dwords from the caller through an index/data pair. It pushes the stored response dwords back through a write strobe with an index.

The engine first checks the mailbox status. It then writes the two header dwords and the payload, and sets Go. It polls for a ready response, bounded by a cycle-count deadline. Every response dword is read and acknowledged. Only the dwords that fit the buffer are kept; the rest are drained and dropped.

Every failure after the pre-checks runs an abort recovery. If the recovery itself cannot clear the mailbox, the engine locks itself out until reset. Completion is a one-cycle `done` pulse. It carries a signed result: the number of bytes stored, or a negative error code.

Top module: `mbx_req_seq`

## Requirements
- R1: A task whose request byte count is not a multiple of 4, or whose capacity is below 4 bytes, completes one cycle after `start` with result -22 and makes no mailbox access. This check takes precedence over the lockout of R2.
- R2: Once locked out, every valid task completes one cycle after `start` with result -5 and makes no mailbox access, until reset.
- R3: The first access of a task reads status (select 0). If Busy (bit 0) is set, the task aborts and returns -16; this wins when Error is also set. If only Error (bit 2) is set, it aborts and returns -5. Nothing is written to the request mailbox in either case.
- R4: The request goes out as writes to the write mailbox (select 2), in this order: {8'h00, type, vendor} with type in bits 23:16; then 2 + payload dwords; then the payload dwords in index order. A control write (select 1) with Go (bit 31) follows.
- R5: After Go, status is polled for Ready (bit 31). Error seen in a poll, even together with Ready, aborts with -5. If no Ready arrives within TIMEOUT_CYC cycles, the task also aborts with -5, and never before that deadline.
- R6: If the first response dword differs from the request in bits 23:0, the task aborts with -5. If the length field (bits 17:0 of the second dword) is below 2, the task aborts with -5 after both header dwords are acknowledged.
- R7: Each response dword is read from select 3 and then acknowledged with a write of zero to select 3. The first min(length-2, capacity/4) payload dwords are stored at indices from 0 upward. The rest are drained. Success returns 4 times the stored count.
- R8: Between reading the last stored dword and its acknowledge, status is read. If Ready is clear, the task aborts with -5. Ready falling after that point has no effect.
- R9: After draining, status is read once more; Error set aborts with -5.
- R10: Abort writes control bit 0. It then reads status every TIMEOUT_CYC/128 cycles until Busy and Error are both clear, and returns the original code. If they are not clear within TIMEOUT_CYC cycles, the original code is still returned and the lockout of R2 begins.
- R11: `done` lasts exactly one cycle. An access request holds its select, direction and data stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Task start pulse, accepted when idle |
| task_vid | input | 16 | Vendor identifier of the object |
| task_type | input | 8 | Object type |
| task_req_bytes | input | BYTES_W | Request payload size in bytes |
| task_rsp_bytes | input | BYTES_W | Response buffer capacity in bytes |
| req_idx | output | BYTES_W-2 | Index of the request payload dword wanted |
| req_word | input | 32 | Request payload dword at `req_idx` |
| rsp_we | output | 1 | Store strobe for one response dword |
| rsp_idx | output | BYTES_W-2 | Buffer index of the stored dword |
| rsp_word | output | 32 | Response dword being stored |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Signed byte count or negative error code |
| bus_req | output | 1 | Register access request, held until acknowledged |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_sel | output | 2 | Register select: 0 status, 1 control, 2 write mailbox, 3 read mailbox |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access acknowledge |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
Two conditions can land on the same status read, and the engine must rank them. The bench's mailbox model raises Busy and Error together before the send. The expected result is the busy code, with an abort and no request writes. The model also sets Error at the moment Go is written, while Ready is already true, so one poll sees both. The expected result is an abort with -5 and no response dword read. A third boundary places the fall of Ready exactly at, and one dword after, the last stored dword. The bench judges failure and success from the result and the acknowledge count.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_WMB  = 2'd2,
    SEL_RMB  = 2'd3
  } sel_e;

  localparam int ST_BUSY_BIT  = 0;
  localparam int ST_ERR_BIT   = 2;
  localparam int ST_RDY_BIT   = 31;
  localparam int CT_ABORT_BIT = 0;
  localparam int CT_GO_BIT    = 31;
  localparam int LEN_W        = 18;

  localparam logic signed [31:0] RC_EIO    = -32'sd5;
  localparam logic signed [31:0] RC_EBUSY  = -32'sd16;
  localparam logic signed [31:0] RC_EINVAL = -32'sd22;

  typedef enum logic [4:0] {
    S_IDLE, S_CHK, S_H1, S_H2, S_PL, S_GO, S_POLL, S_PWAIT,
    S_RH1, S_AH1, S_RH2, S_AH2, S_RDAT, S_RCHK, S_ADAT, S_FIN,
    S_ABW, S_AWAIT, S_ABR
  } st_e;

endpackage

// File: rtl/mbx_bus_port.sv
module mbx_bus_port (
  input  logic        clk,
  input  logic        rst,
  input  logic        issue,
  input  logic        acc_we,
  input  logic [1:0]  acc_sel,
  input  logic [31:0] acc_wdata,
  output logic        acc_done,
  output logic [31:0] acc_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_sel,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_sel   <= 2'd0;
      bus_wdata <= '0;
      acc_done  <= 1'b0;
      acc_rdata <= '0;
    end else begin
      acc_done <= 1'b0;
      if (issue) begin
        bus_req   <= 1'b1;
        bus_we    <= acc_we;
        bus_sel   <= acc_sel;
        bus_wdata <= acc_wdata;
      end else if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        acc_done  <= 1'b1;
        acc_rdata <= bus_rdata;
      end
    end
  end

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_sel) && $stable(bus_we) && $stable(bus_wdata)));

  // R11
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    issue |-> !bus_req);

endmodule

// File: rtl/mbx_timer.sv
module mbx_timer #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic dl_clr,
  input  logic gap_load,
  output logic expired,
  output logic gap_done
);

  localparam int GAP = ((TIMEOUT_CYC >> 7) > 0) ? (TIMEOUT_CYC >> 7) : 1;
  localparam int CW  = $clog2(TIMEOUT_CYC + 1);
  localparam int GW  = $clog2(GAP + 1);

  logic [CW-1:0] dl_cnt;
  logic [GW-1:0] gap_cnt;

  assign expired  = (dl_cnt == CW'(TIMEOUT_CYC));
  assign gap_done = (gap_cnt == '0) && !gap_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      dl_cnt  <= '0;
      gap_cnt <= '0;
    end else begin
      if (dl_clr)
        dl_cnt <= '0;
      else if (!expired)
        dl_cnt <= dl_cnt + 1'b1;
      if (gap_load)
        gap_cnt <= GW'(GAP);
      else if (gap_cnt != '0)
        gap_cnt <= gap_cnt - 1'b1;
    end
  end

  // R5
  tmo_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !dl_clr) |=> expired);

endmodule

// File: rtl/mbx_req_seq.sv
module mbx_req_seq
  import mbx_pkg::*;
#(
  parameter int BYTES_W     = 16,
  parameter int TIMEOUT_CYC = 1024,
  localparam int IDX_W      = BYTES_W - 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [15:0]         task_vid,
  input  logic [7:0]          task_type,
  input  logic [BYTES_W-1:0]  task_req_bytes,
  input  logic [BYTES_W-1:0]  task_rsp_bytes,
  output logic [IDX_W-1:0]    req_idx,
  input  logic [31:0]         req_word,
  output logic                rsp_we,
  output logic [IDX_W-1:0]    rsp_idx,
  output logic [31:0]         rsp_word,
  output logic                done,
  output logic signed [31:0]  result,
  output logic                bus_req,
  output logic                bus_we,
  output logic [1:0]          bus_sel,
  output logic [31:0]         bus_wdata,
  input  logic                bus_ack,
  input  logic [31:0]         bus_rdata
);

  st_e               state;
  logic              pend, dead, dl_clr, gap_load, expired, gap_done;
  logic              issue, in_acc, acc_we, acc_done;
  sel_e              acc_sel;
  logic [31:0]       acc_wdata, rd;
  logic [15:0]       vid_q;
  logic [7:0]        type_q;
  logic [IDX_W-1:0]  req_dw_q, cap_dw_q, pl_i;
  logic [LEN_W-1:0]  len_q, rem_q, keep_q, rx_i, rem_n;
  logic signed [31:0] err_code;
  logic              args_ok;

  assign args_ok = (task_req_bytes[1:0] == 2'b00) && (task_rsp_bytes >= BYTES_W'(4));
  assign req_idx = pl_i;
  assign rem_n   = len_q - LEN_W'(2);

  always_comb begin
    in_acc    = 1'b1;
    acc_we    = 1'b0;
    acc_sel   = SEL_STAT;
    acc_wdata = '0;
    case (state)
      S_CHK, S_POLL, S_RCHK, S_FIN, S_ABR: acc_sel = SEL_STAT;
      S_H1:   begin acc_we = 1'b1; acc_sel = SEL_WMB; acc_wdata = {8'h00, type_q, vid_q}; end
      S_H2:   begin acc_we = 1'b1; acc_sel = SEL_WMB; acc_wdata = 32'(req_dw_q) + 32'd2; end
      S_PL:   begin acc_we = 1'b1; acc_sel = SEL_WMB; acc_wdata = req_word; end
      S_GO:   begin acc_we = 1'b1; acc_sel = SEL_CTRL; acc_wdata = 32'd1 << CT_GO_BIT; end
      S_RH1, S_RH2, S_RDAT: acc_sel = SEL_RMB;
      S_AH1, S_AH2, S_ADAT: begin acc_we = 1'b1; acc_sel = SEL_RMB; end
      S_ABW:  begin acc_we = 1'b1; acc_sel = SEL_CTRL; acc_wdata = 32'd1 << CT_ABORT_BIT; end
      default: in_acc = 1'b0;
    endcase
  end

  assign issue = in_acc && !pend;

  mbx_bus_port u_port (
    .clk(clk), .rst(rst), .issue(issue), .acc_we(acc_we), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .acc_done(acc_done), .acc_rdata(rd),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  mbx_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst(rst), .dl_clr(dl_clr), .gap_load(gap_load),
    .expired(expired), .gap_done(gap_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      pend     <= 1'b0;
      dead     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      rsp_we   <= 1'b0;
      rsp_idx  <= '0;
      rsp_word <= '0;
      dl_clr   <= 1'b0;
      gap_load <= 1'b0;
      vid_q    <= '0;
      type_q   <= '0;
      req_dw_q <= '0;
      cap_dw_q <= '0;
      pl_i     <= '0;
      len_q    <= '0;
      rem_q    <= '0;
      keep_q   <= '0;
      rx_i     <= '0;
      err_code <= '0;
    end else begin
      done     <= 1'b0;
      rsp_we   <= 1'b0;
      dl_clr   <= 1'b0;
      gap_load <= 1'b0;
      if (issue)    pend <= 1'b1;
      if (acc_done) pend <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (!args_ok) begin
            done <= 1'b1; result <= RC_EINVAL;
          end else if (dead) begin
            done <= 1'b1; result <= RC_EIO;
          end else begin
            vid_q    <= task_vid;
            type_q   <= task_type;
            req_dw_q <= task_req_bytes[BYTES_W-1:2];
            cap_dw_q <= task_rsp_bytes[BYTES_W-1:2];
            pl_i     <= '0;
            state    <= S_CHK;
          end
        end
        S_CHK: if (acc_done) begin
          if (rd[ST_BUSY_BIT]) begin
            err_code <= RC_EBUSY; state <= S_ABW;
          end else if (rd[ST_ERR_BIT]) begin
            err_code <= RC_EIO; state <= S_ABW;
          end else state <= S_H1;
        end
        S_H1: if (acc_done) state <= S_H2;
        S_H2: if (acc_done) state <= (req_dw_q == '0) ? S_GO : S_PL;
        S_PL: if (acc_done) begin
          pl_i <= pl_i + 1'b1;
          if (pl_i == req_dw_q - 1'b1) state <= S_GO;
        end
        S_GO: if (acc_done) begin
          dl_clr <= 1'b1; state <= S_POLL;
        end
        S_POLL: if (acc_done) begin
          if (rd[ST_ERR_BIT]) begin
            err_code <= RC_EIO; state <= S_ABW;
          end else if (rd[ST_RDY_BIT]) state <= S_RH1;
          else if (expired) begin
            err_code <= RC_EIO; state <= S_ABW;
          end else begin
            gap_load <= 1'b1; state <= S_PWAIT;
          end
        end
        S_PWAIT: if (gap_done) state <= S_POLL;
        S_RH1: if (acc_done) begin
          if (rd[23:0] == {type_q, vid_q}) state <= S_AH1;
          else begin
            err_code <= RC_EIO; state <= S_ABW;
          end
        end
        S_AH1: if (acc_done) state <= S_RH2;
        S_RH2: if (acc_done) begin
          len_q <= rd[LEN_W-1:0]; state <= S_AH2;
        end
        S_AH2: if (acc_done) begin
          if (len_q < LEN_W'(2)) begin
            err_code <= RC_EIO; state <= S_ABW;
          end else begin
            rem_q  <= rem_n;
            keep_q <= (rem_n > LEN_W'(cap_dw_q)) ? LEN_W'(cap_dw_q) : rem_n;
            rx_i   <= '0;
            state  <= (rem_n == '0) ? S_FIN : S_RDAT;
          end
        end
        S_RDAT: if (acc_done) begin
          if (rx_i < keep_q) begin
            rsp_we   <= 1'b1;
            rsp_idx  <= IDX_W'(rx_i);
            rsp_word <= rd;
            state    <= (rx_i == keep_q - 1'b1) ? S_RCHK : S_ADAT;
          end else state <= S_ADAT;
        end
        S_RCHK: if (acc_done) begin
          if (rd[ST_RDY_BIT]) state <= S_ADAT;
          else begin
            err_code <= RC_EIO; state <= S_ABW;
          end
        end
        S_ADAT: if (acc_done) begin
          if (rx_i == rem_q - 1'b1) state <= S_FIN;
          else begin
            rx_i <= rx_i + 1'b1; state <= S_RDAT;
          end
        end
        S_FIN: if (acc_done) begin
          if (rd[ST_ERR_BIT]) begin
            err_code <= RC_EIO; state <= S_ABW;
          end else begin
            done <= 1'b1; result <= 32'(keep_q) <<< 2; state <= S_IDLE;
          end
        end
        S_ABW: if (acc_done) begin
          dl_clr <= 1'b1; gap_load <= 1'b1; state <= S_AWAIT;
        end
        S_AWAIT: if (gap_done) state <= S_ABR;
        S_ABR: if (acc_done) begin
          if (!rd[ST_BUSY_BIT] && !rd[ST_ERR_BIT]) begin
            done <= 1'b1; result <= err_code; state <= S_IDLE;
          end else if (expired) begin
            dead <= 1'b1; done <= 1'b1; result <= err_code; state <= S_IDLE;
          end else begin
            gap_load <= 1'b1; state <= S_AWAIT;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10
  dead_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    dead |=> dead);

  // R7
  store_bound_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_we |-> (32'(rsp_idx) < 32'(cap_dw_q)));

  // R1
  inval_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && !args_ok) |=> (done && result == RC_EINVAL && !bus_req));

  // R2
  dead_fast_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start && args_ok && dead) |=> (done && result == RC_EIO && !bus_req));

endmodule

// File: tb/mbx_req_seq_tb.sv
`timescale 1ns/1ps
module mbx_req_seq_tb_top;

  localparam int TMO = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 1'b0;
  logic [15:0] t_vid = '0;
  logic [7:0]  t_type = '0;
  logic [15:0] t_rq = '0, t_cap = '0;
  logic [13:0] req_idx, rsp_idx;
  logic [31:0] req_word, rsp_word, bus_wdata, bus_rdata;
  logic        rsp_we, done, bus_req, bus_we, bus_ack;
  logic [1:0]  bus_sel;
  logic signed [31:0] result;

  logic [31:0] req_pl [16];
  logic [31:0] rsp_mem [16];
  logic [31:0] rbuf [16];
  logic [31:0] wlog [16];
  assign req_word = req_pl[req_idx[3:0]];

  mbx_req_seq #(.BYTES_W(16), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .start(start), .task_vid(t_vid), .task_type(t_type),
    .task_req_bytes(t_rq), .task_rsp_bytes(t_cap), .req_idx(req_idx), .req_word(req_word),
    .rsp_we(rsp_we), .rsp_idx(rsp_idx), .rsp_word(rsp_word), .done(done), .result(result),
    .bus_req(bus_req), .bus_we(bus_we), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // mailbox model
  logic cfg_load = 0, cfg_busy = 0, cfg_err = 0, cfg_err_go = 0, cfg_err_end = 0;
  logic cfg_no_rdy = 0, cfg_stuck = 0;
  int   rsp_len = 0, rdy_lim = 0;
  logic st_busy = 0, st_err = 0, go_seen = 0, ack_r = 0;
  logic [31:0] rdat_r = '0;
  int rd_ptr = 0, wcnt = 0, ack_cnt = 0, bad_ack = 0, aborts = 0, stat_reads = 0, acc_cnt = 0;
  logic rdy;
  assign rdy = go_seen && !cfg_no_rdy && (rd_ptr < rdy_lim);
  assign bus_ack = ack_r;
  assign bus_rdata = rdat_r;

  always @(posedge clk) begin
    if (cfg_load) begin
      rd_ptr <= 0; go_seen <= 0; st_busy <= cfg_busy; st_err <= cfg_err;
      wcnt <= 0; ack_cnt <= 0; bad_ack <= 0; aborts <= 0; stat_reads <= 0; ack_r <= 0;
    end else if (bus_req && !ack_r) begin
      ack_r <= 1'b1;
      acc_cnt <= acc_cnt + 1;
      if (!bus_we) begin
        if (bus_sel == 2'd0) begin
          stat_reads <= stat_reads + 1;
          rdat_r <= {rdy, 28'd0, st_err, 1'b0, st_busy};
        end else if (bus_sel == 2'd3) rdat_r <= rsp_mem[rd_ptr[3:0]];
        else rdat_r <= '0;
      end else begin
        if (bus_sel == 2'd1) begin
          if (bus_wdata[0]) begin
            aborts <= aborts + 1; rd_ptr <= 0; go_seen <= 0;
            if (!cfg_stuck) begin st_busy <= 0; st_err <= 0; end
          end
          if (bus_wdata[31]) begin
            go_seen <= 1;
            if (cfg_err_go) st_err <= 1;
          end
        end else if (bus_sel == 2'd2) begin
          wlog[wcnt[3:0]] <= bus_wdata; wcnt <= wcnt + 1;
        end else if (bus_sel == 2'd3) begin
          ack_cnt <= ack_cnt + 1;
          if (bus_wdata != 0) bad_ack <= bad_ack + 1;
          rd_ptr <= rd_ptr + 1;
          if (cfg_err_end && rd_ptr + 1 == rsp_len) st_err <= 1;
        end
      end
    end else ack_r <= 1'b0;
  end

  always @(negedge clk) if (rsp_we) rbuf[rsp_idx[3:0]] <= rsp_word;

  int checks = 0, errors = 0;
  int res = 0, cyc = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input bit busy, input bit err, input bit err_go, input bit err_end,
                       input bit no_rdy, input bit stuck);
    cfg_busy = busy; cfg_err = err; cfg_err_go = err_go; cfg_err_end = err_end;
    cfg_no_rdy = no_rdy; cfg_stuck = stuck;
    for (int k = 0; k < 16; k++) rbuf[k] = '0;
    @(negedge clk) cfg_load = 1;
    @(negedge clk) cfg_load = 0;
  endtask

  task automatic prep_rsp(input logic [15:0] v, input logic [7:0] ty, input int lenf, input int npl);
    rsp_mem[0] = {8'h00, ty, v};
    rsp_mem[1] = lenf;
    for (int k = 0; k < 14; k++) rsp_mem[k+2] = 32'hC0DE0000 + k;
    rsp_len = 2 + npl;
    rdy_lim = rsp_len;
  endtask

  task automatic run(input logic [15:0] v, input logic [7:0] ty, input int rqb, input int capb);
    @(negedge clk);
    t_vid = v; t_type = ty; t_rq = rqb[15:0]; t_cap = capb[15:0]; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 1;
    while (!done && cyc < 8000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R11: task watchdog, done actual 0 expected 1");
    end
    res = result;
  endtask

  localparam logic [47:0] VEC [6] = '{
    {8'd1, 16'd4,  8'd1, 16'd4},
    {8'd0, 16'd8,  8'd3, 16'd8},
    {8'd3, 16'd16, 8'd2, 16'd8},
    {8'd2, 16'd4,  8'd0, 16'd0},
    {8'd4, 16'd32, 8'd5, 16'd20},
    {8'd1, 16'd12, 8'd3, 16'd12}
  };

  initial begin
    for (int k = 0; k < 16; k++) begin req_pl[k] = '0; wlog[k] = '0; end
    prep_rsp(16'h0, 8'h0, 2, 0);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(done == 0, "R11 reset done", done, 0);
    check(bus_req == 0, "R11 reset bus_req", bus_req, 0);

    // main vectors: R4, R7
    for (int i = 0; i < 6; i++) begin
      automatic int rdw = VEC[i][47:40];
      automatic int capb = VEC[i][39:24];
      automatic int npl = VEC[i][23:16];
      automatic int exp = VEC[i][15:0];
      automatic logic [15:0] v = 16'h1E00 + 16'(i);
      automatic logic [7:0] ty = 8'h10 + 8'(i);
      automatic int keep = exp / 4;
      automatic int errs_before = errors;
      for (int k = 0; k < 16; k++) req_pl[k] = 32'h5A000000 | (i << 8) | k;
      prep_rsp(v, ty, 2 + npl, npl);
      setup(0, 0, 0, 0, 0, 0);
      run(v, ty, rdw * 4, capb);
      check(res == exp, "R7 result", res, exp);
      for (int k = 0; k < keep; k++)
        check(rbuf[k] == 32'hC0DE0000 + k, "R7 stored word", rbuf[k], 32'hC0DE0000 + k);
      check(ack_cnt == 2 + npl && bad_ack == 0, "R7 acknowledges", ack_cnt, 2 + npl);
      check(wcnt == 2 + rdw, "R4 write count", wcnt, 2 + rdw);
      check(wlog[0] == {8'h00, ty, v}, "R4 header one", wlog[0], {8'h00, ty, v});
      check(wlog[1] == 2 + rdw, "R4 header two", wlog[1], 2 + rdw);
      for (int k = 0; k < rdw; k++)
        check(wlog[k+2] == req_pl[k], "R4 payload", wlog[k+2], req_pl[k]);
      check(go_seen == 1 && aborts == 0, "R4 go written", go_seen, 1);
      @(negedge clk);
      check(done == 0, "R11 done one cycle", done, 0);
      if (errors != errs_before) $display("  in vector %0d", i);
    end

    // R1 bad sizes
    setup(0, 0, 0, 0, 0, 0);
    begin
      automatic int a0 = acc_cnt;
      run(16'h1, 8'h1, 6, 8);
      check(res == -22 && cyc == 1, "R1 odd request bytes", res, -22);
      run(16'h1, 8'h1, 4, 3);
      check(res == -22 && cyc == 1, "R1 capacity below one dword", res, -22);
      check(acc_cnt == a0, "R1 no access", acc_cnt - a0, 0);
    end

    // R3 busy and error together: busy wins
    prep_rsp(16'h2, 8'h2, 3, 1);
    setup(1, 1, 0, 0, 0, 0);
    run(16'h2, 8'h2, 4, 4);
    check(res == -16, "R3 busy code", res, -16);
    check(wcnt == 0 && aborts == 1, "R3 abort no writes", wcnt, 0);
    setup(0, 1, 0, 0, 0, 0);
    run(16'h2, 8'h2, 4, 4);
    check(res == -5 && aborts == 1, "R3 error code", res, -5);
    // R10 successful abort leaves mailbox usable
    setup(0, 0, 0, 0, 0, 0);
    run(16'h2, 8'h2, 4, 4);
    check(res == 4, "R10 usable after abort", res, 4);

    // R5 error with ready on same poll
    setup(0, 0, 1, 0, 0, 0);
    run(16'h2, 8'h2, 4, 4);
    check(res == -5 && aborts == 1, "R5 poll error", res, -5);
    check(ack_cnt == 0, "R5 no response read", ack_cnt, 0);
    // R5 never ready
    setup(0, 0, 0, 0, 1, 0);
    run(16'h2, 8'h2, 4, 4);
    check(res == -5 && aborts == 1, "R5 timeout abort", res, -5);
    check(cyc >= TMO && stat_reads > 2, "R5 not before deadline", cyc, TMO);

    // R6 header mismatch
    prep_rsp(16'h3, 8'h4, 3, 1);
    setup(0, 0, 0, 0, 0, 0);
    run(16'h3, 8'h3, 0, 4);
    check(res == -5 && aborts == 1 && ack_cnt == 0, "R6 header mismatch", res, -5);
    // R6 short length
    prep_rsp(16'h3, 8'h3, 1, 0);
    setup(0, 0, 0, 0, 0, 0);
    run(16'h3, 8'h3, 0, 4);
    check(res == -5 && ack_cnt == 2, "R6 length below two", res, -5);

    // R8 ready gone at last stored dword
    prep_rsp(16'h4, 8'h4, 6, 4);
    rdy_lim = 3;
    setup(0, 0, 0, 0, 0, 0);
    run(16'h4, 8'h4, 4, 8);
    check(res == -5 && aborts == 1, "R8 ready lost", res, -5);
    // R8 ready gone one dword later: no effect
    prep_rsp(16'h4, 8'h4, 6, 4);
    rdy_lim = 4;
    setup(0, 0, 0, 0, 0, 0);
    run(16'h4, 8'h4, 4, 8);
    check(res == 8 && ack_cnt == 6, "R8 late drop ignored", res, 8);

    // R9 error after drain
    prep_rsp(16'h5, 8'h5, 5, 3);
    setup(0, 0, 0, 1, 0, 0);
    run(16'h5, 8'h5, 4, 4);
    check(res == -5 && ack_cnt == 5 && aborts == 1, "R9 final error", res, -5);

    // R10 abort never clears -> lockout, R2
    prep_rsp(16'h6, 8'h6, 3, 1);
    setup(0, 0, 1, 0, 0, 1);
    run(16'h6, 8'h6, 4, 4);
    check(res == -5, "R10 stuck abort code", res, -5);
    check(stat_reads > 40 && stat_reads < 140, "R10 abort poll rate", stat_reads, 80);
    setup(0, 0, 0, 0, 0, 0);
    begin
      automatic int a0 = acc_cnt;
      run(16'h6, 8'h6, 4, 4);
      check(res == -5 && cyc == 1, "R2 locked out", res, -5);
      run(16'h6, 8'h6, 5, 4);
      check(res == -22, "R1 size check before lockout", res, -22);
      check(acc_cnt == a0, "R2 no access", acc_cnt - a0, 0);
    end
    @(negedge clk) rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    setup(0, 0, 0, 0, 0, 0);
    run(16'h6, 8'h6, 4, 4);
    check(res == 4, "R2 reset clears lockout", res, 4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule